// File: doc/BRIEF.md
# One-Bit Quadrature AM Downconverter

This block turns a single-bit, heavily oversampled RF stream into an AM audio envelope. The stream usually comes from a comparator that acts as a delta-sigma converter, and each bit stands for +1 or -1. An on-chip phase-accumulator oscillator is tuned to the wanted carrier. Because the input is one bit, the mixer needs no multiplier. It passes the oscillator's cosine and sine, or their negations, to give I and Q at zero IF.

Each branch then runs through its own three-stage CIC decimator, which adds resolution as it lowers the rate. The detector takes the integer square root of I² + Q². This makes the audio level independent of the phase drift between the free-running oscillator and the carrier.

A tuning word can be loaded at any time through a one-cycle load strobe. Each decimated sample gives one unsigned audio word, marked by a one-cycle valid pulse.

Top module: `onebitAmRx`

## Requirements
- R1: An input bit of 1 means +1 and 0 means -1. The I product equals the oscillator cosine when the bit is 1 and its two's-complement negation when it is 0. The Q product does the same with the sine. Both products are registered one clock after the oscillator sample and the input bit.
- R2: A PHASE_W-bit phase accumulator adds the active tuning word on every clock. Its top TABLE_BITS+2 bits form an index i into a full wave of 2^(TABLE_BITS+2) points. The registered sine output is round(A·sin(2π(i+0.5)/2^(TABLE_BITS+2))) with A = 2^(LO_W-1)-1, rounding half away from zero. The cosine output uses index i + 2^TABLE_BITS, modulo the wave length.
- R3: When tuneLoad is high at a clock edge, tuneWord becomes the active tuning word, and phase increments use it from the next edge on. Loading does not disturb the accumulated phase.
- R4: Each of I and Q passes through a CIC filter with CIC_STAGES integrators at the input rate, followed by the same number of differential-delay-1 combs at the decimated rate. All CIC registers are LO_W + CIC_STAGES·DECIM_LOG2 bits wide and wrap in two's complement.
- R5: Decimation happens on every 2^DECIM_LOG2-th clock edge after reset release. The first audioValid pulse is seen after edge number 2^DECIM_LOG2 + CIC_W + 2, counted from reset release, where CIC_W is the CIC register width.
- R6: audioOut equals floor(sqrt(I² + Q²)) of the decimated CIC outputs. It is computed by a bit-serial restoring square root that finishes before the next decimated sample arrives.
- R7: audioValid is high for exactly one cycle per decimated sample. Consecutive pulses are exactly 2^DECIM_LOG2 cycles apart.
- R8: A synchronous active-high reset clears the phase accumulator, the tuning word, every integrator and comb register, the mixer products, audioOut and audioValid.
- R9: With the tuning word equal to the carrier's phase step, the output settles to a large, steady level whatever the phase offset between carrier and oscillator, including a 90° offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one RF sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rfIn | input | 1 | One-bit RF sample (1 = +1, 0 = -1) |
| tuneLoad | input | 1 | Load strobe for the tuning word |
| tuneWord | input | PHASE_W | Phase step per clock for the oscillator |
| audioOut | output | LO_W+CIC_STAGES·DECIM_LOG2 | Unsigned envelope sample |
| audioValid | output | 1 | One-cycle pulse marking a new audioOut |

## Verification
The bench builds the block with TABLE_BITS = 6 and DECIM_LOG2 = 5, which gives a 256-point oscillator wave, decimation by 32 and 27-bit CIC registers. The square root then takes 27 steps against a 32-cycle sample period, so the tight window between finishing a result and the next decimation is exercised on every sample. The CIC gain of 2^15 brings a matched carrier close to full scale of the CIC registers. The short period also lets constant, matched-carrier, quadrature-offset, pseudo-random and retuned inputs, plus a reset in mid-run, all be checked against the reference model within one short run.

// File: rtl/amRxPkg.sv
package amRxPkg;

  // Strobes issued by the sequencer to the datapath
  typedef struct packed {
    logic decim;   // take a decimated CIC sample this edge
    logic load;    // capture I^2 + Q^2 into the root engine
    logic step;    // one restoring square-root iteration
    logic finish;  // publish the root as an audio sample
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LOAD,
    S_STEP,
    S_DONE
  } seqState_t;

endpackage

// File: rtl/amNco.sv
module amNco #(
  parameter int PHASE_W    = 32,
  parameter int LO_W       = 12,
  parameter int TABLE_BITS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tuneLoad,
  input  logic [PHASE_W-1:0]       tuneWord,
  output logic signed [LO_W-1:0]   loSin,
  output logic signed [LO_W-1:0]   loCos
);

  localparam int QSIZE  = 1 << TABLE_BITS;
  localparam int ADDR_W = TABLE_BITS + 2;
  localparam int AMP    = (1 << (LO_W - 1)) - 1;

  // Quarter-wave samples taken at half-step offsets so the four quadrants mirror exactly
  function automatic logic signed [LO_W-1:0] quarterPoint(int k);
    real ang;
    real val;
    ang = 1.57079632679489661923 * (real'(k) + 0.5) / real'(QSIZE);
    val = real'(AMP) * $sin(ang);
    return LO_W'($rtoi(val + 0.5));
  endfunction

  logic signed [LO_W-1:0] quarterTab [QSIZE];
  for (genvar g = 0; g < QSIZE; g++) begin : g_tab
    assign quarterTab[g] = quarterPoint(g);
  end

  logic [PHASE_W-1:0] phaseAcc;
  logic [PHASE_W-1:0] tuneReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseAcc <= '0;
      tuneReg  <= '0;
    end else begin
      phaseAcc <= phaseAcc + tuneReg;
      if (tuneLoad) tuneReg <= tuneWord;
    end
  end

  // Address 0 reads the sine; address 1 sits a quarter turn ahead for the cosine
  logic [ADDR_W-1:0] waveAddr [2];
  assign waveAddr[0] = phaseAcc[PHASE_W-1 -: ADDR_W];
  assign waveAddr[1] = waveAddr[0] + ADDR_W'(QSIZE);

  for (genvar w = 0; w < 2; w++) begin : g_wave
    logic [TABLE_BITS-1:0]  tabIdx;
    logic signed [LO_W-1:0] tabMag;
    logic signed [LO_W-1:0] waveVal;
    always_comb begin
      tabIdx  = waveAddr[w][ADDR_W-2] ? ~waveAddr[w][TABLE_BITS-1:0]
                                      :  waveAddr[w][TABLE_BITS-1:0];
      tabMag  = quarterTab[tabIdx];
      waveVal = waveAddr[w][ADDR_W-1] ? -tabMag : tabMag;
    end
  end

  always_ff @(posedge clk) begin
    loSin <= g_wave[0].waveVal;
    loCos <= g_wave[1].waveVal;
  end

  AST_LO_UNIT_CIRCLE: assert property (@(posedge clk) disable iff (rst)
    ((int'(loSin) * int'(loSin) + int'(loCos) * int'(loCos)) <= (AMP + 1) * (AMP + 1)) &&
    ((int'(loSin) * int'(loSin) + int'(loCos) * int'(loCos)) >= (AMP - 1) * (AMP - 1))); // R2

endmodule

// File: rtl/amCic.sv
module amCic #(
  parameter int IN_W   = 12,
  parameter int STAGES = 3,
  parameter int ACC_W  = 30
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [IN_W-1:0]   sampleIn,
  input  logic                     decimate,
  output logic signed [ACC_W-1:0]  sampleOut
);

  logic signed [ACC_W-1:0] integ   [STAGES];
  logic signed [ACC_W-1:0] combDly [STAGES];
  logic signed [ACC_W-1:0] combVal [STAGES+1];

  // Integrator chain at the input rate, wraparound arithmetic
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) integ[s] <= '0;
    end else begin
      integ[0] <= integ[0] + ACC_W'(sampleIn);
      for (int s = 1; s < STAGES; s++) integ[s] <= integ[s] + integ[s-1];
    end
  end

  // Comb chain evaluated combinationally, state updated only on a decimation edge
  assign combVal[0] = integ[STAGES-1];
  for (genvar s = 0; s < STAGES; s++) begin : g_comb
    assign combVal[s+1] = combVal[s] - combDly[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) combDly[s] <= '0;
      sampleOut <= '0;
    end else if (decimate) begin
      for (int s = 0; s < STAGES; s++) combDly[s] <= combVal[s];
      sampleOut <= combVal[STAGES];
    end
  end

endmodule

// File: rtl/amRxDatapath.sv
module amRxDatapath
  import amRxPkg::*;
#(
  parameter int PHASE_W    = 32,
  parameter int LO_W       = 12,
  parameter int TABLE_BITS = 8,
  parameter int CIC_STAGES = 3,
  parameter int CIC_W      = 30
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rfIn,
  input  logic                tuneLoad,
  input  logic [PHASE_W-1:0]  tuneWord,
  input  ctrlStrobes_t        ctl,
  output logic [CIC_W-1:0]    audioOut,
  output logic                audioValid
);

  localparam int RAD_W = 2 * CIC_W;
  localparam int REM_W = CIC_W + 3;

  logic signed [LO_W-1:0] loSin;
  logic signed [LO_W-1:0] loCos;

  amNco #(
    .PHASE_W    (PHASE_W),
    .LO_W       (LO_W),
    .TABLE_BITS (TABLE_BITS)
  ) u_nco (
    .clk      (clk),
    .rst      (rst),
    .tuneLoad (tuneLoad),
    .tuneWord (tuneWord),
    .loSin    (loSin),
    .loCos    (loCos)
  );

  // Sign-flip mixer: index 0 is I (cosine), index 1 is Q (sine)
  logic signed [LO_W-1:0] mixVal [2];
  always_ff @(posedge clk) begin
    if (rst) begin
      mixVal[0] <= '0;
      mixVal[1] <= '0;
    end else begin
      mixVal[0] <= rfIn ? loCos : -loCos;
      mixVal[1] <= rfIn ? loSin : -loSin;
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_chan
    logic signed [CIC_W-1:0] chanOut;
    amCic #(
      .IN_W   (LO_W),
      .STAGES (CIC_STAGES),
      .ACC_W  (CIC_W)
    ) u_cic (
      .clk       (clk),
      .rst       (rst),
      .sampleIn  (mixVal[c]),
      .decimate  (ctl.decim),
      .sampleOut (chanOut)
    );
  end

  logic signed [CIC_W-1:0] cicI;
  logic signed [CIC_W-1:0] cicQ;
  assign cicI = g_chan[0].chanOut;
  assign cicQ = g_chan[1].chanOut;

  logic signed [RAD_W-1:0] sqI;
  logic signed [RAD_W-1:0] sqQ;
  logic [RAD_W-1:0]        sumSq;
  always_comb begin
    sqI   = RAD_W'(cicI) * RAD_W'(cicI);
    sqQ   = RAD_W'(cicQ) * RAD_W'(cicQ);
    sumSq = sqI + sqQ;
  end

  // Restoring square root, two radicand bits per step
  logic [RAD_W-1:0] radicand;
  logic [REM_W-1:0] rem;
  logic [CIC_W-1:0] root;
  logic [REM_W-1:0] remShift;
  logic [REM_W-1:0] trial;
  logic             takeBit;

  always_comb begin
    remShift = {rem[REM_W-3:0], radicand[RAD_W-1 -: 2]};
    trial    = REM_W'({root, 2'b01});
    takeBit  = remShift >= trial;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      radicand <= '0;
      rem      <= '0;
      root     <= '0;
    end else if (ctl.load) begin
      radicand <= sumSq;
      rem      <= '0;
      root     <= '0;
    end else if (ctl.step) begin
      radicand <= radicand << 2;
      rem      <= takeBit ? (remShift - trial) : remShift;
      root     <= {root[CIC_W-2:0], takeBit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      audioOut   <= '0;
      audioValid <= 1'b0;
    end else begin
      audioValid <= ctl.finish;
      if (ctl.finish) audioOut <= root;
    end
  end

  AST_MIX_SIGN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(loCos) != 0) |->
      (((mixVal[0] == $past(loCos)) == $past(rfIn)) &&
       ((mixVal[0] == $past(loCos)) || (mixVal[0] == -$past(loCos))))); // R1

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    audioValid |=> !audioValid); // R7

endmodule

// File: rtl/amRxControl.sv
module amRxControl
  import amRxPkg::*;
#(
  parameter int DECIM_LOG2 = 6,
  parameter int ROOT_STEPS = 30
) (
  input  logic         clk,
  input  logic         rst,
  output ctrlStrobes_t ctl
);

  localparam int STEP_CNT_W = $clog2(ROOT_STEPS + 1);

  logic [DECIM_LOG2-1:0] decCnt;
  logic [STEP_CNT_W-1:0] stepCnt;
  seqState_t             state;
  logic                  decimTick;

  assign decimTick = &decCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      decCnt  <= '0;
      stepCnt <= '0;
      state   <= S_IDLE;
    end else begin
      decCnt <= decCnt + 1'b1;
      case (state)
        S_IDLE: if (decimTick) state <= S_LOAD;
        S_LOAD: begin
          stepCnt <= '0;
          state   <= S_STEP;
        end
        S_STEP: begin
          if (stepCnt == STEP_CNT_W'(ROOT_STEPS - 1)) state <= S_DONE;
          else stepCnt <= stepCnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.decim  = decimTick;
    ctl.load   = (state == S_LOAD);
    ctl.step   = (state == S_STEP);
    ctl.finish = (state == S_DONE);
  end

  AST_ROOT_BEFORE_NEXT: assert property (@(posedge clk) disable iff (rst)
    decimTick |-> (state == S_IDLE)); // R6

endmodule

// File: rtl/onebitAmRx.sv
module onebitAmRx
  import amRxPkg::*;
#(
  parameter int PHASE_W    = 32,
  parameter int LO_W       = 12,
  parameter int TABLE_BITS = 8,
  parameter int CIC_STAGES = 3,
  parameter int DECIM_LOG2 = 6
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     rfIn,
  input  logic                                     tuneLoad,
  input  logic [PHASE_W-1:0]                       tuneWord,
  output logic [LO_W+CIC_STAGES*DECIM_LOG2-1:0]    audioOut,
  output logic                                     audioValid
);

  localparam int CIC_W = LO_W + CIC_STAGES * DECIM_LOG2;

  ctrlStrobes_t ctl;

  amRxControl #(
    .DECIM_LOG2 (DECIM_LOG2),
    .ROOT_STEPS (CIC_W)
  ) u_ctrl (
    .clk (clk),
    .rst (rst),
    .ctl (ctl)
  );

  amRxDatapath #(
    .PHASE_W    (PHASE_W),
    .LO_W       (LO_W),
    .TABLE_BITS (TABLE_BITS),
    .CIC_STAGES (CIC_STAGES),
    .CIC_W      (CIC_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .rfIn       (rfIn),
    .tuneLoad   (tuneLoad),
    .tuneWord   (tuneWord),
    .ctl        (ctl),
    .audioOut   (audioOut),
    .audioValid (audioValid)
  );

endmodule

// File: tb/onebitAmRx_test.sv
module onebitAmRx_test;

  localparam int PHASE_W    = 32;
  localparam int LO_W       = 12;
  localparam int TABLE_BITS = 6;
  localparam int STAGES     = 3;
  localparam int DECIM_LOG2 = 5;
  localparam int DECIM      = 1 << DECIM_LOG2;
  localparam int OUT_W      = LO_W + STAGES * DECIM_LOG2;
  localparam int LAT        = DECIM + OUT_W + 2;
  localparam int WAVE_PTS   = 1 << (TABLE_BITS + 2);
  localparam real AMP       = 2047.0;
  localparam longint STRONG = 20000000;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               rfIn = 1'b0;
  logic               tuneLoad = 1'b0;
  logic [PHASE_W-1:0] tuneWord = '0;
  logic [OUT_W-1:0]   audioOut;
  logic               audioValid;

  always #5 clk = ~clk;

  onebitAmRx #(
    .PHASE_W    (PHASE_W),
    .LO_W       (LO_W),
    .TABLE_BITS (TABLE_BITS),
    .CIC_STAGES (STAGES),
    .DECIM_LOG2 (DECIM_LOG2)
  ) uut (
    .clk        (clk),
    .rst        (rst),
    .rfIn       (rfIn),
    .tuneLoad   (tuneLoad),
    .tuneWord   (tuneWord),
    .audioOut   (audioOut),
    .audioValid (audioValid)
  );

  int    total = 0;
  int    bad = 0;
  bit    finished = 0;
  string curTag = "R8";

  task automatic check(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int refWave(int idx);
    real x;
    x = AMP * $sin(2.0 * 3.14159265358979323846 * (real'(idx) + 0.5) / real'(WAVE_PTS));
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic longint wrapW(longint v);
    return (v <<< (64 - OUT_W)) >>> (64 - OUT_W);
  endfunction

  function automatic longint isqrt(longint v);
    longint r;
    r = longint'($sqrt(real'(v)));
    while (r * r > v) r--;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  // Behavioural reference model, advanced on every rising edge
  bit [31:0] mPh = '0;
  bit [31:0] mTune = '0;
  int        mLoS = 0;
  int        mLoC = 0;
  longint    mMix [2];
  longint    mInt [2][STAGES];
  longint    mDly [2][STAGES];
  int        mDec = 0;
  longint    expQ [$];
  longint    cycleNo = 0;
  longint    sinceRst = 0;

  always @(posedge clk) begin
    int idx;
    int nS;
    int nC;
    longint x;
    longint y;
    longint cOut [2];
    idx = int'(mPh[31 -: TABLE_BITS + 2]);
    nS  = refWave(idx);
    nC  = refWave((idx + WAVE_PTS / 4) % WAVE_PTS);
    cycleNo++;
    if (rst) begin
      mPh = '0; mTune = '0; mDec = 0; sinceRst = 0;
      for (int c = 0; c < 2; c++) begin
        mMix[c] = 0;
        for (int s = 0; s < STAGES; s++) begin mInt[c][s] = 0; mDly[c][s] = 0; end
      end
      expQ.delete();
    end else begin
      sinceRst++;
      if (mDec == DECIM - 1) begin
        for (int c = 0; c < 2; c++) begin
          x = mInt[c][STAGES-1];
          for (int s = 0; s < STAGES; s++) begin
            y = wrapW(x - mDly[c][s]);
            mDly[c][s] = x;
            x = y;
          end
          cOut[c] = x;
        end
        expQ.push_back(isqrt(cOut[0] * cOut[0] + cOut[1] * cOut[1]));
      end
      mDec = (mDec + 1) % DECIM;
      for (int c = 0; c < 2; c++) begin
        for (int s = STAGES - 1; s >= 1; s--) mInt[c][s] = wrapW(mInt[c][s] + mInt[c][s-1]);
        mInt[c][0] = wrapW(mInt[c][0] + mMix[c]);
      end
      mMix[0] = rfIn ? mLoC : -mLoC;
      mMix[1] = rfIn ? mLoS : -mLoS;
      mPh = mPh + mTune;
      if (tuneLoad) mTune = tuneWord;
    end
    mLoS = nS;
    mLoC = nC;
  end

  // Output comparison away from the active edge
  bit     gotFirst = 0;
  bit     prevValid = 0;
  longint lastValid = 0;
  longint lastMag = 0;

  always @(negedge clk) begin
    longint e;
    if (rst) begin
      gotFirst = 0;
    end else if (audioValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, {curTag, " unexpected sample"}, longint'(audioOut), -1);
      end else begin
        e = expQ.pop_front();
        check(longint'(audioOut) == e, curTag, longint'(audioOut), e);
      end
      if (!gotFirst) check(sinceRst == LAT, "R5 first-sample latency", sinceRst, LAT);
      else check(cycleNo - lastValid == DECIM, "R7 valid spacing", cycleNo - lastValid, DECIM);
      gotFirst  = 1;
      lastValid = cycleNo;
      lastMag   = longint'(audioOut);
    end
    if (audioValid && prevValid) check(1'b0, "R7 valid held two cycles", 2, 1);
    prevValid = audioValid;
  end

  // Stimulus
  int        mode = 0;
  bit        rfConst = 1'b1;
  bit [31:0] carrierPh = '0;
  bit [31:0] carrierStep = '0;
  bit [15:0] lfsr = 16'hACE1;

  task automatic runCycles(int n);
    repeat (n) begin
      @(negedge clk);
      case (mode)
        0: rfIn = rfConst;
        1: begin
          carrierPh = carrierPh + carrierStep;
          rfIn = ~carrierPh[31];
        end
        default: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          rfIn = lfsr[0];
        end
      endcase
    end
  endtask

  task automatic loadTune(bit [31:0] v);
    @(negedge clk);
    tuneLoad = 1'b1;
    tuneWord = v;
    @(negedge clk);
    tuneLoad = 1'b0;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(audioValid == 1'b0, "R8 valid cleared by reset", longint'(audioValid), 0);
    check(audioOut == '0, "R8 audio cleared by reset", longint'(audioOut), 0);
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(audioValid == 1'b0, "R8 valid low in reset", longint'(audioValid), 0);
    check(audioOut == '0, "R8 audio zero in reset", longint'(audioOut), 0);
    rst = 1'b0;

    // R1 R4 R6: zero tuning word, input held at +1 then -1
    curTag = "R1 R4 R6 constant high input";
    mode = 0; rfConst = 1'b1;
    runCycles(8 * DECIM + LAT);
    curTag = "R1 R4 R6 constant low input";
    rfConst = 1'b0;
    runCycles(8 * DECIM);

    // R2 R3 R9: matched carrier, in phase
    curTag = "R2 R3 R9 matched carrier";
    carrierStep = 32'h0A00_0000;
    loadTune(carrierStep);
    carrierPh = '0;
    mode = 1;
    runCycles(10 * DECIM);
    check(lastMag > STRONG, "R9 strong envelope, in phase", lastMag, STRONG);

    // R8 R9: reset mid-run, then a quarter-turn offset carrier
    applyReset();
    curTag = "R8 R9 quarter-turn offset carrier";
    loadTune(carrierStep);
    carrierPh = 32'h4000_0000;
    runCycles(10 * DECIM + LAT);
    check(lastMag > STRONG, "R9 strong envelope at 90 degrees", lastMag, STRONG);

    // R3: retune while running, no reset
    curTag = "R3 R2 retune mid-run";
    loadTune(32'h1234_5679);
    runCycles(6 * DECIM);

    // R4 R6: pseudo-random input, CIC wraparound and root on varied values
    curTag = "R4 R6 pseudo-random input";
    mode = 2;
    loadTune(32'h3C00_0001);
    runCycles(12 * DECIM);

    // R3: back to matched carrier on the fly
    curTag = "R3 R9 retune to carrier";
    mode = 1;
    loadTune(carrierStep);
    runCycles(8 * DECIM);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R5 R7 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule